// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple host request port and an asynchronous EDO DRAM that has a multiplexed address bus. A host request carries a 17-bit word address, a write flag and write data. The controller splits the address into a 9-bit row part and an 8-bit column part. It first places the row on the shared address bus and drops RAS. It then places the column on the bus and pulses CAS. Every edge of RAS and CAS is gated by down-counters, and each minimum timing is a parameter given in controller clock cycles.

The row stays open after a request completes. A later request to the same row is served with one more CAS pulse and no new activation. A request to a different row first raises RAS, waits out the precharge time, and then opens the new row. If no request arrives for a programmable number of cycles, the controller closes the row itself, so a row is never held open without limit. Writes use the early-write sequence: WE falls and the controller drives the data bus before CAS falls, which keeps the DRAM pins in high impedance. Reads keep WE high, drive OE low and capture the data bus at the end of the CAS pulse.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, ras_n, cas_n, we_n and oe_n are all 1, rd_valid is 0 and req_ready is 1.
- R2: For request address A, dram_addr carries A[16:8] when ras_n falls and {1'b0, A[7:0]} when cas_n falls.
- R3: Every ras_n low period lasts at least T_RAS clock cycles.
- R4: Every ras_n high period that ends in a fall lasts at least T_RP cycles.
- R5: cas_n is low only while ras_n is low, and every cas_n high period that ends in a fall lasts at least T_CP cycles.
- R6: For a read, we_n stays 1 and oe_n is 0 while cas_n is low. cas_n stays low for exactly T_CAS cycles. dq is captured at the edge where cas_n rises, and it is returned on rd_data with a one-cycle rd_valid pulse.
- R7: For a write, we_n is already 0 and dq already carries the write data in the cycle before cas_n falls, and oe_n stays 1.
- R8: A request whose address bits [16:8] match the open row causes no new ras_n fall.
- R9: A request to another row raises ras_n, waits out the precharge and then opens the new row, so each such request adds exactly one ras_n fall.
- R10: With a row open and no request for IDLE_CYC cycles, ras_n returns to 1 once T_RAS is satisfied.
- R11: Only one request is in flight. req_ready is 0 from the cycle after acceptance until the access finishes, including the whole time cas_n is low.
- R12: cas_n falls no sooner than T_RCD cycles after ras_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address, row in [16:8], column in [7:0] |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds read data |
| rd_data | output | 16 | Captured read data |
| dram_addr | output | 9 | Multiplexed row/column address bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq | inout | 16 | Bidirectional DRAM data bus |

## Verification
The bench connects a behavioural DRAM model that latches row and column on the strobe edges. It drives this model with four kinds of traffic:
- Runs of writes and reads within one row, which show that page hits reuse the open row with no new activation.
- Alternating rows, which force the close–precharge–reopen path and expose a wrong hit compare.
- A long pause, which shows that the idle close happens and that the next access reopens the row.
- Address extremes, together with a mixed sequence, which catch row/column bit errors and stale read data.

Strobe widths measured at the pins separate a miscounted timer from a sequencing fault.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_SHUT,
    ST_ACTIVATE,
    ST_COL_PREP,
    ST_CAS_FALL,
    ST_CAS_HOLD,
    ST_IDLE_OPEN,
    ST_CLOSE
  } edo_state_e;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_wait_cnt.sv
module edo_wait_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W    = 9,
  parameter int IDLE_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_en,
  input  logic             idle_run,
  input  logic [ROW_W-1:0] req_row,
  output logic             hit,
  output logic             timeout
);

  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [ROW_W-1:0] row_q;
  logic             live_q;
  logic [IW-1:0]    idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      live_q <= 1'b0;
    end else if (open_en) begin
      row_q  <= open_row;
      live_q <= 1'b1;
    end else if (close_en) begin
      live_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !idle_run) begin
      idle_q <= '0;
    end else if (idle_q != IW'(IDLE_CYC - 1)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign hit     = live_q && (row_q == req_row);
  assign timeout = idle_run && live_q && (idle_q == IW'(IDLE_CYC - 1));

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int COL_W    = 8,
  parameter int DW       = 16,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int T_CP     = 2,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int IDLE_CYC = 20,
  parameter int CNT_W    = 8,
  localparam int AW      = ROW_W + COL_W,
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [MA_W-1:0] dram_addr,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            oe_n,
  inout  wire  [DW-1:0]   dq
);

  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_CP  = CNT_W'(T_CP - 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(T_CAS - 1);

  edo_state_e state_q;

  logic             p_wr_q;
  logic [AW-1:0]    p_addr_q;
  logic [DW-1:0]    p_wdata_q;
  logic             p_go_q;
  logic             dq_oe;
  logic [DW-1:0]    dq_out;

  logic             accept;
  logic             wt_done, ras_done;
  logic             wt_load;
  logic [CNT_W-1:0] wt_val;
  logic             act_go, prep_go, cas_go, hold_end, close_go;
  logic             row_hit, idle_timeout;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;

  assign p_row = p_addr_q[AW-1 -: ROW_W];
  assign p_col = p_addr_q[COL_W-1:0];

  assign req_ready = (state_q == ST_IDLE_SHUT) || (state_q == ST_IDLE_OPEN);
  assign accept    = req_valid && req_ready;

  always_comb begin
    act_go   = (state_q == ST_ACTIVATE) && wt_done;
    prep_go  = (state_q == ST_COL_PREP) && wt_done;
    cas_go   = (state_q == ST_CAS_FALL);
    hold_end = (state_q == ST_CAS_HOLD) && wt_done;
    close_go = (state_q == ST_CLOSE) && ras_done;
    wt_load  = act_go || cas_go || hold_end || close_go;
    if (act_go)        wt_val = LD_RCD;
    else if (cas_go)   wt_val = LD_CAS;
    else if (hold_end) wt_val = LD_CP;
    else               wt_val = LD_RP;
  end

  edo_wait_cnt #(.W(CNT_W)) step_cnt_i (
    .clk (clk),
    .rst (rst),
    .load(wt_load),
    .val (wt_val),
    .done(wt_done)
  );

  edo_wait_cnt #(.W(CNT_W)) ras_cnt_i (
    .clk (clk),
    .rst (rst),
    .load(act_go),
    .val (LD_RAS),
    .done(ras_done)
  );

  edo_row_track #(.ROW_W(ROW_W), .IDLE_CYC(IDLE_CYC)) row_i (
    .clk     (clk),
    .rst     (rst),
    .open_en (act_go),
    .open_row(p_row),
    .close_en(close_go),
    .idle_run(state_q == ST_IDLE_OPEN),
    .req_row (req_addr[AW-1 -: ROW_W]),
    .hit     (row_hit),
    .timeout (idle_timeout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE_SHUT;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      dram_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      p_wr_q    <= 1'b0;
      p_addr_q  <= '0;
      p_wdata_q <= '0;
      p_go_q    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        p_wr_q    <= req_write;
        p_addr_q  <= req_addr;
        p_wdata_q <= req_wdata;
      end
      case (state_q)
        ST_IDLE_SHUT: begin
          if (accept) state_q <= ST_ACTIVATE;
        end
        ST_ACTIVATE: begin
          if (act_go) begin
            ras_n     <= 1'b0;
            dram_addr <= MA_W'(p_row);
            state_q   <= ST_COL_PREP;
          end
        end
        ST_COL_PREP: begin
          if (prep_go) begin
            dram_addr <= MA_W'(p_col);
            we_n      <= ~p_wr_q;
            oe_n      <= p_wr_q;
            dq_oe     <= p_wr_q;
            dq_out    <= p_wdata_q;
            state_q   <= ST_CAS_FALL;
          end
        end
        ST_CAS_FALL: begin
          cas_n   <= 1'b0;
          state_q <= ST_CAS_HOLD;
        end
        ST_CAS_HOLD: begin
          if (hold_end) begin
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (!p_wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dq;
            end
            state_q <= ST_IDLE_OPEN;
          end
        end
        ST_IDLE_OPEN: begin
          if (accept) begin
            p_go_q  <= 1'b1;
            state_q <= row_hit ? ST_COL_PREP : ST_CLOSE;
          end else if (idle_timeout) begin
            p_go_q  <= 1'b0;
            state_q <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (close_go) begin
            ras_n   <= 1'b1;
            state_q <= p_go_q ? ST_ACTIVATE : ST_IDLE_SHUT;
          end
        end
        default: state_q <= ST_IDLE_SHUT;
      endcase
    end
  end

  assign dq = dq_oe ? dq_out : {DW{1'bz}};

endmodule

// File: rtl/edo_page_chk.sv
module edo_page_chk #(
  parameter int T_RAS = 5,
  parameter int T_RP  = 3,
  parameter int T_CP  = 2,
  parameter int T_RCD = 2
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ready
);

  localparam logic [15:0] SAT = 16'hFFFF;

  logic [15:0] ras_lo_len, ras_hi_len, cas_hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_lo_len <= '0;
      ras_hi_len <= 16'(T_RP);
      cas_hi_len <= 16'(T_CP);
    end else begin
      ras_lo_len <= ras_n ? '0 : ((ras_lo_len == SAT) ? SAT : ras_lo_len + 1'b1);
      ras_hi_len <= !ras_n ? '0 : ((ras_hi_len == SAT) ? SAT : ras_hi_len + 1'b1);
      cas_hi_len <= !cas_n ? '0 : ((cas_hi_len == SAT) ? SAT : cas_hi_len + 1'b1);
    end
  end

  // R3
  ras_active_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (ras_lo_len >= 16'(T_RAS)));

  // R4
  ras_precharge_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (ras_hi_len >= 16'(T_RP)));

  // R5
  cas_precharge_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (cas_hi_len >= 16'(T_CP)));

  // R5
  cas_inside_row_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  // R12
  ras_to_cas_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (ras_lo_len >= 16'(T_RCD)));

  // R7
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe && oe_n));

  // R6
  read_out_en_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !dq_oe));

  // R11
  busy_in_cas_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !req_ready);

endmodule

bind edo_page_ctrl edo_page_chk #(
  .T_RAS(T_RAS),
  .T_RP (T_RP),
  .T_CP (T_CP),
  .T_RCD(T_RCD)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .dq_oe    (dq_oe),
  .req_ready(req_ready)
);

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb_top;

  localparam int T_RAS    = 5;
  localparam int T_RP     = 3;
  localparam int T_CP     = 2;
  localparam int T_RCD    = 2;
  localparam int T_CAS    = 2;
  localparam int IDLE_CYC = 20;

  typedef struct {
    bit          wr;
    logic [16:0] addr;
    logic [15:0] data;
  } op_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [8:0]  dram_addr;
  logic        ras_n, cas_n, we_n, oe_n;
  wire  [15:0] dq;

  logic        mdl_drv;
  logic [15:0] mdl_val;
  logic [8:0]  m_row;
  logic        last_we;

  int n_cmp = 0;
  int n_bad = 0;
  int ras_falls = 0;
  int cyc = 0;

  logic [15:0] mem    [int];
  logic [15:0] shadow [int];
  op_t         op_q[$];
  logic [15:0] rd_q[$];

  always #4 clk = ~clk;

  edo_page_ctrl #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .IDLE_CYC(IDLE_CYC)
  ) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .dq(dq)
  );

  assign mdl_drv = !ras_n && !cas_n && we_n && !oe_n;
  assign dq = mdl_drv ? mdl_val : 16'hzzzz;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // DRAM model: row on RAS fall, column and write on CAS fall
  always @(negedge ras_n) begin
    if (!rst) begin
      m_row = dram_addr;
      ras_falls++;
    end
  end

  always @(negedge cas_n) begin
    if (!rst) begin
      op_t o;
      int  key;
      key = int'({m_row, dram_addr[7:0]});
      if (op_q.size() == 0) begin
        chk(1'b0, "R11 unexpected CAS", 0, 1);
      end else begin
        o = op_q.pop_front();
        chk({m_row, dram_addr[7:0]} == o.addr, "R2 row/col split", {m_row, dram_addr[7:0]}, o.addr);
        chk(dram_addr[8] == 1'b0, "R2 column upper bit", dram_addr[8], 0);
        chk(we_n == !o.wr, "R6/R7 WE level at CAS", we_n, !o.wr);
        if (o.wr) begin
          chk(dq == o.data, "R7 write data at CAS", dq, o.data);
          chk(last_we == 1'b0, "R7 WE before CAS", last_we, 0);
          chk(oe_n == 1'b1, "R7 OE high on write", oe_n, 1);
          mem[key] = dq;
        end else begin
          chk(oe_n == 1'b0, "R6 OE low on read", oe_n, 0);
        end
      end
      mdl_val = mem.exists(key) ? mem[key] : 16'h0000;
    end
  end

  // Pin-level timing monitor and read scoreboard
  int  ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100;
  logic p_ras = 1'b1, p_cas = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!cas_n && ras_n) chk(1'b0, "R5 CAS low outside row", 0, 1);
      if (ras_n && !p_ras) chk(ras_lo >= T_RAS, "R3 RAS low width", ras_lo, T_RAS);
      if (!ras_n && p_ras) chk(ras_hi >= T_RP, "R4 precharge width", ras_hi, T_RP);
      if (!cas_n && p_cas) begin
        chk(cas_hi >= T_CP, "R5 CAS high width", cas_hi, T_CP);
        chk(ras_lo >= T_RCD, "R12 RAS to CAS", ras_lo, T_RCD);
      end
      if (cas_n && !p_cas) chk(cas_lo == T_CAS, "R6 CAS low width", cas_lo, T_CAS);
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      cas_lo = cas_n ? 0 : cas_lo + 1;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      p_ras = ras_n;
      p_cas = cas_n;
      last_we = we_n;
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(1'b0, "R6 unexpected rd_valid", 1, 0);
        else begin
          logic [15:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R6 read data", rd_data, e);
        end
      end
    end
  end

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [15:0] d);
    op_t o;
    o.wr = wr; o.addr = a; o.data = d;
    op_q.push_back(o);
    if (wr) shadow[int'(a)] = d;
    else rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
  endtask

  task automatic drain();
    while (rd_q.size() != 0 || op_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", cyc, 150000);
        report();
      end
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    last_we = 1'b1; mdl_val = '0; m_row = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes after reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // R8 page hits in one row
    do_req(1'b1, 17'h00501, 16'hA1A1);
    do_req(1'b1, 17'h00502, 16'hB2B2);
    do_req(1'b0, 17'h00501, 16'h0);
    do_req(1'b0, 17'h00502, 16'h0);
    drain();
    chk(ras_falls == 1, "R8 single activation for hits", ras_falls, 1);

    // R9 row miss
    do_req(1'b0, 17'h00901, 16'h0);
    do_req(1'b1, 17'h009FF, 16'h5A5A);
    do_req(1'b0, 17'h009FF, 16'h0);
    drain();
    chk(ras_falls == 2, "R9 one reopen on miss", ras_falls, 2);
    do_req(1'b0, 17'h00502, 16'h0);
    drain();
    chk(ras_falls == 3, "R9 reopen old row", ras_falls, 3);

    // R10 idle close
    repeat (IDLE_CYC + T_RAS + 10) @(negedge clk);
    chk(ras_n == 1'b1, "R10 row closed when idle", ras_n, 1);
    chk(ras_falls == 3, "R10 no activation while idle", ras_falls, 3);
    do_req(1'b0, 17'h00501, 16'h0);
    drain();
    chk(ras_falls == 4, "R10 reopen after idle close", ras_falls, 4);

    // R2 address extremes
    do_req(1'b1, 17'h1FFFF, 16'hC3C3);
    do_req(1'b1, 17'h00000, 16'h3C3C);
    do_req(1'b0, 17'h1FFFF, 16'h0);
    do_req(1'b0, 17'h00000, 16'h0);

    // Mixed traffic: runs of four per row across three rows
    for (int i = 0; i < 24; i++) begin
      logic [8:0] r;
      r = (i / 4) % 3 == 0 ? 9'h003 : ((i / 4) % 3 == 1 ? 9'h1A0 : 9'h0F5);
      do_req(1'b1, {r, 8'(i * 37)}, 16'(i * 4099 + 7));
    end
    for (int i = 23; i >= 0; i--) begin
      logic [8:0] r;
      r = (i / 4) % 3 == 0 ? 9'h003 : ((i / 4) % 3 == 1 ? 9'h1A0 : 9'h0F5);
      do_req(1'b0, {r, 8'(i * 37)}, 16'h0);
    end
    drain();
    repeat (5) @(negedge clk);
    chk(rd_q.size() == 0, "R6 all reads returned", rd_q.size(), 0);
    report();
  end

endmodule